// File: doc/BRIEF.md
# Serial Flash Hold and Power-State Front End

This block sits between the pins of a serial flash slave and its command logic. It brings chip select, serial clock and the pause (hold) pin into the system clock domain through synchronisers. It then issues one shift-enable pulse for each serial clock rising edge that the shift logic should accept. It also owns the output-enable of the data-out pin. While the host has paused the bus, clock edges are discarded and the data-out pin floats. The serial bit position is kept, so the transfer continues from the same bit once the pause ends.

A pause only takes effect when the serial clock is low at the moment the pause pin changes. A pause pin edge seen while the clock is high is held pending until the next falling clock edge. The block also reports standby. After the host deselects the device, standby waits until the internal program/erase/status-write engine reports idle. A pause never aborts that engine.

Top module: `spi_hold_pwr_ctrl`

## Requirements
- R1: While reset is asserted, `sdo_oe`, `standby`, `shift_en` and `bit_cnt` are all 0.
- R2: With the device selected, a falling edge of `hold_n_pin` while `sck_pin` is low starts the pause. `sdo_oe` drops to 0.
- R3: A falling edge of `hold_n_pin` while `sck_pin` is high leaves the bus running until the next falling edge of `sck_pin`, which then starts the pause.
- R4: A rising edge of `hold_n_pin` while `sck_pin` is low ends the pause. `sdo_oe` returns to 1.
- R5: A rising edge of `hold_n_pin` while `sck_pin` is high keeps the pause until the next falling edge of `sck_pin`.
- R6: During a pause, rising edges of `sck_pin` produce no `shift_en` pulse and leave `bit_cnt` unchanged. Counting resumes from the retained value after the pause.
- R7: `cs_n_pin` high cancels any pause, forces `sdo_oe` to 0 and returns `bit_cnt` to 0.
- R8: While the device is selected and not paused, each rising edge of `sck_pin` gives exactly one `shift_en` pulse and advances `bit_cnt` by one, modulo 2^BIT_W.
- R9: `standby` is 1 only when `cs_n_pin` is high and `wr_busy` is low. A deselect during a busy cycle keeps `standby` at 0 until `wr_busy` falls, and a pause does not change this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| hold_n_pin | input | 1 | Pause pin, active low, asynchronous |
| wr_busy | input | 1 | Internal write/program/erase engine busy |
| shift_en | output | 1 | One-cycle pulse per accepted serial clock rising edge |
| sdo_oe | output | 1 | Output-enable for the data-out pin |
| bit_cnt | output | BIT_W | Serial bit position within the current unit |
| standby | output | 1 | Device in standby power state |

## Verification
On every cycle, the assertions check four things. No shift pulse occurs and the bit position stays put during a pause. A pause only starts or ends on a cycle where the synchronised clock was low. Deselect clears the pause and the bit counter, and a busy engine always keeps standby off. The bench scenarios cover the rest: the deferred entry and exit when the pause pin moves with the clock high, the bit count resuming after a pause, and standby waiting for the engine to finish after a deselect.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    PS_RUN        = 2'd0,
    PS_ENTER_WAIT = 2'd1,
    PS_PAUSED     = 2'd2,
    PS_EXIT_WAIT  = 2'd3
  } pause_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] d;
    if (s == 0) begin : g_first
      assign d = pin_async;
    end else begin : g_rest
      assign d = chain[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= d;
    end
  end

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic sck_rise,
  output logic paused
);
  pause_state_e state_q, state_d;
  logic sck_q, hold_n_q;
  logic sck_fall, hold_fall, hold_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      hold_n_q <= 1'b1;
    end else begin
      sck_q    <= sck_s;
      hold_n_q <= hold_n_s;
    end
  end

  assign sck_rise  =  sck_s & ~sck_q;
  assign sck_fall  = ~sck_s &  sck_q;
  assign hold_fall = ~hold_n_s &  hold_n_q;
  assign hold_rise =  hold_n_s & ~hold_n_q;

  always_comb begin
    state_d = state_q;
    if (cs_n_s) begin
      state_d = PS_RUN;
    end else begin
      unique case (state_q)
        PS_RUN:        if (hold_fall) state_d = sck_s ? PS_ENTER_WAIT : PS_PAUSED;
        PS_ENTER_WAIT: if (hold_rise)     state_d = PS_RUN;
                       else if (sck_fall) state_d = PS_PAUSED;
        PS_PAUSED:     if (hold_rise) state_d = sck_s ? PS_EXIT_WAIT : PS_RUN;
        PS_EXIT_WAIT:  if (hold_fall)     state_d = PS_PAUSED;
                       else if (sck_fall) state_d = PS_RUN;
        default:       state_d = PS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_d;
  end

  assign paused = (state_q == PS_PAUSED) || (state_q == PS_EXIT_WAIT);

  AST_PAUSE_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(sck_s)); // R2
  AST_PAUSE_EXIT_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused) && !$past(cs_n_s)) |-> !$past(sck_s)); // R4
  AST_DESELECT_CLEARS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !paused); // R7
endmodule

// File: rtl/spi_bit_counter.sv
module spi_bit_counter #(
  parameter int unsigned BIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             frozen,
  output logic [BIT_W-1:0] count
);
  logic [BIT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_COUNT_FROZEN_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clear) |=> $stable(cnt_q)); // R6
  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/spi_hold_pwr_ctrl.sv
module spi_hold_pwr_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BIT_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_pin,
  input  logic             sck_pin,
  input  logic             hold_n_pin,
  input  logic             wr_busy,
  output logic             shift_en,
  output logic             sdo_oe,
  output logic [BIT_W-1:0] bit_cnt,
  output logic             standby
);
  localparam int unsigned NPIN = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b101; // {cs_n, sck, hold_n}

  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  logic [NPIN-1:0] pins_s;
  logic cs_n_s, sck_s, hold_n_s;

  spi_pin_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_async ({cs_n_pin, sck_pin, hold_n_pin}),
    .pin_sync  (pins_s)
  );
  assign {cs_n_s, sck_s, hold_n_s} = pins_s;

  logic sck_rise, paused;

  spi_hold_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_n_s   (cs_n_s),
    .sck_s    (sck_s),
    .hold_n_s (hold_n_s),
    .sck_rise (sck_rise),
    .paused   (paused)
  );

  logic step_en;
  assign step_en = sck_rise & ~cs_n_s & ~paused;

  spi_bit_counter #(.BIT_W(BIT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clear  (cs_n_s),
    .step   (step_en),
    .frozen (paused),
    .count  (bit_cnt)
  );

  logic standby_q, standby_d;
  assign standby_d = cs_n_s & ~wr_busy;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) standby_q <= 1'b0;
    else            standby_q <= standby_d;
  end

  assign shift_en = step_en;
  assign sdo_oe   = ~cs_n_s & ~paused;
  assign standby  = standby_q;

  AST_NO_SHIFT_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    paused |-> !shift_en); // R6
  AST_BUSY_BLOCKS_STANDBY: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_busy |=> !standby); // R9
  AST_NO_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(cs_n_s) && cs_n_s |-> !sdo_oe); // R7
endmodule

// File: tb/spi_hold_pwr_ctrl_bench.sv
module spi_hold_pwr_ctrl_bench;
  localparam int unsigned BIT_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n_pin, sck_pin, hold_n_pin, wr_busy;
  logic shift_en, sdo_oe, standby;
  logic [BIT_W-1:0] bit_cnt;

  int n_checks = 0;
  int n_errors = 0;
  int pulses   = 0;

  always #2 clk = ~clk; // 250 MHz

  spi_hold_pwr_ctrl #(.SYNC_STAGES(2), .BIT_W(BIT_W)) u_spi_hold_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
    .hold_n_pin(hold_n_pin), .wr_busy(wr_busy), .shift_en(shift_en),
    .sdo_oe(sdo_oe), .bit_cnt(bit_cnt), .standby(standby)
  );

  always @(posedge clk) if (shift_en) pulses <= pulses + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic sck_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sck_pin = 1'b1; repeat (4) @(negedge clk);
      sck_pin = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  // {cs_n, sck, hold_n, busy, exp_oe, exp_standby}
  localparam logic [5:0] VEC [15] = '{
    6'b1_0_1_0_0_1,  // deselected idle -> standby R9
    6'b1_0_1_1_0_0,  // deselected but busy -> active R9
    6'b0_0_1_1_1_0,  // selected
    6'b0_0_0_1_0_0,  // pause, sck low R2
    6'b0_0_1_1_1_0,  // resume, sck low R4
    6'b0_1_1_1_1_0,  // sck high
    6'b0_1_0_1_1_0,  // pause pin falls with sck high: pending R3
    6'b0_0_0_1_0_0,  // sck falls: paused R3
    6'b0_1_0_1_0_0,  // still paused
    6'b0_1_1_1_0_0,  // pause pin rises with sck high: still paused R5
    6'b0_0_1_1_1_0,  // sck falls: resumed R5
    6'b0_0_0_1_0_0,  // pause while busy R9
    6'b1_0_0_1_0_0,  // deselect during pause, busy keeps active R7 R9
    6'b1_0_0_0_0_1,  // busy done -> standby R9
    6'b0_0_1_0_1_0   // selected again, pause cleared R7
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n_pin = 1'b1; sck_pin = 1'b0; hold_n_pin = 1'b1; wr_busy = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 standby", standby, 0);
    chk("R1 shift_en", shift_en, 0);
    chk("R1 bit_cnt", bit_cnt, 0);
    rst_n = 1'b1;
    settle();

    for (int v = 0; v < 15; v++) begin
      {cs_n_pin, sck_pin, hold_n_pin, wr_busy} = VEC[v][5:2];
      settle();
      chk($sformatf("R2-5/R7/R9 vec%0d sdo_oe", v), sdo_oe, VEC[v][1]);
      chk($sformatf("R9 vec%0d standby", v), standby, VEC[v][0]);
    end

    // Bit counting and pause retention
    cs_n_pin = 1'b1; hold_n_pin = 1'b1; sck_pin = 1'b0; settle();
    cs_n_pin = 1'b0; settle();
    pulses = 0;
    sck_pulses(3);
    chk("R8 bit_cnt after 3 edges", bit_cnt, 3);
    chk("R8 pulse count", pulses, 3);
    hold_n_pin = 1'b0; settle();
    sck_pulses(2);
    chk("R6 bit_cnt frozen in pause", bit_cnt, 3);
    chk("R6 no pulses in pause", pulses, 3);
    hold_n_pin = 1'b1; settle();
    sck_pulses(2);
    chk("R6 bit_cnt resumes", bit_cnt, 5);
    sck_pulses(3);
    chk("R8 bit_cnt wraps", bit_cnt, 0);
    sck_pulses(2);
    hold_n_pin = 1'b0; settle();
    cs_n_pin = 1'b1; settle();
    chk("R7 bit_cnt cleared", bit_cnt, 0);
    chk("R7 sdo_oe off", sdo_oe, 0);
    cs_n_pin = 1'b0; hold_n_pin = 1'b1; settle();
    chk("R7 pause cancelled", sdo_oe, 1);

    // Reset mid-transfer
    sck_pulses(1);
    rst_n = 1'b0; @(negedge clk);
    chk("R1 bit_cnt in reset", bit_cnt, 0);
    chk("R1 sdo_oe in reset", sdo_oe, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule